// File: doc/BRIEF.md
# Power-Gating Interval Controller

This block decides when a host microcontroller gets power. It drives an active-low gate enable: low switches the supply to the host on, and high switches it off. Time is counted in ticks of a slow strobe, for example one per millisecond. A programmed interval, given as a tick count, sets how far apart the enable windows start. The block waits until the configuration reader reports that the interval is valid. It then samples a mode strap once and opens its first window. In periodic mode a new window opens at every interval boundary. In one-shot mode only the first window opens by itself.

Inside a window the host shows it has finished by raising DONE. The block passes DONE through a two-flop synchronizer and a rising-edge detector, and the first edge closes the window at once. If no DONE arrives, the window closes a fixed guard time before the next boundary, so the host is always off before a new cycle begins. A validated, debounced manual power-on level also turns the host on when it is off. While that level is held, the host stays on, all counting stays cleared and DONE is ignored. Counting starts again from zero when the level is released. None of the block's inputs or outputs carries a data stream, so it has no valid/ready interface and every pin is a plain control signal.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until `cfg_ready` is first seen high, `gate_n` is 1. The first window starts on the clock edge that samples `cfg_ready` high, so `gate_n` is 0 one cycle later.
- R2: In periodic mode (strap = 1), successive falling edges of `gate_n` are exactly `interval_ticks` ticks apart.
- R3: With no DONE, each window keeps `gate_n` low for exactly `interval_ticks - GUARD_TICKS` ticks (GUARD_TICKS defaults to 50). `gate_n` then stays high until the boundary.
- R4: The first rising edge of `done_in` inside a window drives `gate_n` high within 3 clock cycles. Later edges in the same interval have no effect, and the next boundary does not move.
- R5: In one-shot mode (strap = 0), exactly one window follows startup. After it, `gate_n` stays high until a manual power-on.
- R6: A rising edge of `man_hold` while `gate_n` is high drives `gate_n` low on the next cycle. `gate_n` stays low as long as `man_hold` is high, even beyond the interval. The clock edge that sees `man_hold` low again starts a fresh window of R3 length and a fresh interval.
- R7: A rising edge of `man_hold` while `gate_n` is low is ignored: the window ends and the next boundary arrives at their normal times.
- R8: DONE edges that arrive while `man_hold` is high are ignored.
- R9: The mode strap is latched when `cfg_ready` is accepted. Later changes to it have no effect.
- R10: When `interval_ticks <= GUARD_TICKS`, the window length saturates at zero and `gate_n` never goes low by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe; one strobe is one time unit |
| interval_ticks | input | CW | Programmed interval in ticks |
| periodic_strap | input | 1 | 1 = periodic, 0 = one-shot; sampled once |
| cfg_ready | input | 1 | Configuration read finished; the interval is valid |
| done_in | input | 1 | Host completion signal, asynchronous |
| man_hold | input | 1 | Validated manual power-on level, synchronous |
| gate_n | output | 1 | Active-low power enable for the host |

## Verification
The hardest case to reach is a manual power-on that covers an interval boundary while a DONE edge arrives during the hold. It needs the block in its off phase, in a mode and at a time where a boundary or a DONE would otherwise change the output. The stimulus first lets a one-shot window end by itself and waits well past the next boundary. It then holds the manual level for longer than a whole interval and pulses DONE in the middle of the hold. The periodic test instead presses the manual level late in the off phase, so the hold crosses a boundary. Both tests then time the restarted window and the next boundary from the release edge.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [2:0] {
    PG_WAIT = 3'd0,
    PG_ON   = 3'd1,
    PG_OFF  = 3'd2,
    PG_IDLE = 3'd3,
    PG_MAN  = 3'd4
  } pg_state_e;
endpackage

// File: rtl/pgc_edge_sync.sv
module pgc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= 1'b0;
    else        pipe[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= 1'b0;
      else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= pipe[STAGES-1];
  end

  assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/pgc_window_len.sv
module pgc_window_len #(
  parameter int CW          = 16,
  parameter int GUARD_TICKS = 50
) (
  input  logic [CW-1:0] interval,
  output logic [CW-1:0] win_len,
  output logic          win_zero
);
  localparam logic [CW-1:0] GUARD_W = CW'(GUARD_TICKS);

  always_comb begin
    if (interval > GUARD_W) win_len = interval - GUARD_W;
    else                    win_len = '0;
    win_zero = (win_len == '0);
  end
endmodule

// File: rtl/pgc_fsm.sv
module pgc_fsm
  import pgc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [CW-1:0]   interval,
  input  logic [CW-1:0]   win_len,
  input  logic            win_zero,
  input  logic            strap,
  input  logic            cfg_ready,
  input  logic            done_rise,
  input  logic            man_hold,
  output logic            gate_n,
  output pg_state_e       state,
  output logic            mode_per
);
  pg_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          mode_q, mode_d;
  logic          man_q, man_rise;
  logic          gate_q;
  pg_state_e     open_st;

  assign man_rise = man_hold & ~man_q;
  assign cnt_inc  = cnt_q + 1'b1;
  assign open_st  = win_zero ? PG_OFF : PG_ON;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    case (state_q)
      PG_WAIT: begin
        if (cfg_ready) begin
          mode_d  = strap;
          cnt_d   = '0;
          state_d = open_st;
        end
      end
      PG_ON: begin
        if (tick) cnt_d = cnt_inc;
        if ((done_rise && !man_hold) || (tick && cnt_inc >= win_len))
          state_d = PG_OFF;
      end
      PG_OFF: begin
        if (man_rise) begin
          state_d = PG_MAN;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt_inc >= interval) begin
            cnt_d   = '0;
            state_d = mode_q ? open_st : PG_IDLE;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      PG_IDLE: begin
        if (man_rise) begin
          state_d = PG_MAN;
          cnt_d   = '0;
        end
      end
      PG_MAN: begin
        cnt_d = '0;
        if (!man_hold) state_d = open_st;
      end
      default: state_d = PG_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_WAIT;
      cnt_q   <= '0;
      mode_q  <= 1'b1;
      man_q   <= 1'b0;
      gate_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      man_q   <= man_hold;
      gate_q  <= !(state_d == PG_ON || state_d == PG_MAN);
    end
  end

  assign gate_n   = gate_q;
  assign state    = state_q;
  assign mode_per = mode_q;
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int GUARD_TICKS = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] interval_ticks,
  input  logic          periodic_strap,
  input  logic          cfg_ready,
  input  logic          done_in,
  input  logic          man_hold,
  output logic          gate_n
);
  logic          done_rise;
  logic [CW-1:0] win_len;
  logic          win_zero;
  pg_state_e     fsm_state;
  logic          mode_q;

  pgc_edge_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (done_in),
    .rise (done_rise)
  );

  pgc_window_len #(.CW(CW), .GUARD_TICKS(GUARD_TICKS)) u_win (
    .interval(interval_ticks),
    .win_len (win_len),
    .win_zero(win_zero)
  );

  pgc_fsm #(.CW(CW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .interval (interval_ticks),
    .win_len  (win_len),
    .win_zero (win_zero),
    .strap    (periodic_strap),
    .cfg_ready(cfg_ready),
    .done_rise(done_rise),
    .man_hold (man_hold),
    .gate_n   (gate_n),
    .state    (fsm_state),
    .mode_per (mode_q)
  );
endmodule

// File: rtl/pgc_sva.sv
module pgc_sva
  import pgc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cfg_ready,
  input logic      man_hold,
  input logic      gate_n,
  input logic      done_rise,
  input pg_state_e state,
  input logic      mode_q
);
  logic seen_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_cfg <= 1'b0;
    else if (cfg_ready) seen_cfg <= 1'b1;
  end

  AST_GATE_OFF_PRECFG: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_cfg |-> gate_n); // R1

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_ON && done_rise && !man_hold) |=> gate_n); // R4

  AST_MAN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PG_OFF || state == PG_IDLE) && $rose(man_hold)) |=> !gate_n); // R6

  AST_MAN_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_MAN && man_hold) |=> !gate_n); // R6

  AST_MAN_IGNORED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_ON && $rose(man_hold)) |=> state != PG_MAN); // R7

  AST_DONE_IGNORED_MAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_MAN && man_hold && done_rise) |=> !gate_n); // R8

  AST_ONESHOT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_IDLE && !$rose(man_hold)) |=> state == PG_IDLE); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cfg && state != PG_WAIT) |=> $stable(mode_q)); // R9
endmodule

bind pwr_gate_ctrl pgc_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_ready(cfg_ready),
  .man_hold (man_hold),
  .gate_n   (gate_n),
  .done_rise(done_rise),
  .state    (fsm_state),
  .mode_q   (mode_q)
);

// File: tb/pwr_gate_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_gate_ctrl_tb;
  localparam int CW  = 16;
  localparam int GRD = 50;
  localparam int LIM = 6000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] interval_ticks = '0;
  logic          periodic_strap = 1'b1;
  logic          cfg_ready = 1'b0;
  logic          done_in = 1'b0;
  logic          man_hold = 1'b0;
  logic          gate_n;

  int cyc = 0;
  int div = 1;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  pwr_gate_ctrl #(.CW(CW), .GUARD_TICKS(GRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .interval_ticks(interval_ticks),
    .periodic_strap(periodic_strap), .cfg_ready(cfg_ready), .done_in(done_in),
    .man_hold(man_hold), .gate_n(gate_n)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph   = (ph + 1 >= div) ? 0 : ph + 1;
      tick = (ph == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_level(input logic lvl);
    int n;
    n = 0;
    while (gate_n !== lvl && n < LIM) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic start(input int iv, input bit per, input int d);
    @(negedge clk);
    rst_n = 1'b0; cfg_ready = 1'b0; done_in = 1'b0; man_hold = 1'b0;
    interval_ticks = CW'(iv); periodic_strap = per; div = d;
    repeat (4) @(negedge clk);
    chk("R1 gate during reset", int'(gate_n), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 gate before cfg_ready", int'(gate_n), 1);
    cfg_ready = 1'b1;
    @(negedge clk);
    chk("R1 first window opens", int'(gate_n), (iv > GRD) ? 0 : 1);
  endtask

  task automatic pulse_done();
    done_in = 1'b1;
    repeat (3) @(negedge clk);
    done_in = 1'b0;
  endtask

  task automatic sweep_one(input int iv, input int d);
    int tf, tr, lows;
    start(iv, 1'b1, d);
    if (iv > GRD) begin
      wait_level(1'b1);
      wait_level(1'b0); tf = cyc;
      wait_level(1'b1); tr = cyc;
      chk("R3 window length", tr - tf, (iv - GRD) * d);
      wait_level(1'b0);
      chk("R2 fall-to-fall period", cyc - tf, iv * d);
    end else begin
      lows = 0;
      repeat (3 * iv * d + 30) begin
        @(negedge clk);
        if (!gate_n) lows++;
      end
      chk("R10 zero window never low", lows, 0);
    end
  endtask

  initial begin
    int tf, tr, trel, lows, highs;
    // Sweep: interval across the guard boundary, two tick rates
    for (int d = 1; d <= 3; d += 2) begin
      for (int iv = 46; iv <= 56; iv++) sweep_one(iv, d);
      sweep_one(100, d);
      sweep_one(131, d);
    end

    // R4: DONE closes window, repeats ignored, boundary unchanged
    start(100, 1'b1, 1);
    tf = cyc;
    repeat (10) @(negedge clk);
    pulse_done();
    chk("R4 first DONE closes window", int'(gate_n), 1);
    repeat (5) @(negedge clk);
    pulse_done();
    repeat (5) @(negedge clk);
    chk("R4 second DONE no effect", int'(gate_n), 1);
    wait_level(1'b0);
    chk("R4 boundary unchanged", cyc - tf, 100);
    tf = cyc;
    wait_level(1'b1);
    chk("R3 next window full length", cyc - tf, 50);

    // R7: manual while low ignored; R6 manual restart in periodic mode
    start(100, 1'b1, 1);
    tf = cyc;
    repeat (5) @(negedge clk);
    man_hold = 1'b1;
    repeat (10) @(negedge clk);
    man_hold = 1'b0;
    wait_level(1'b1); tr = cyc;
    chk("R7 window end unchanged", tr - tf, 50);
    wait_level(1'b0);
    chk("R7 boundary unchanged", cyc - tf, 100);
    wait_level(1'b1);
    repeat (20) @(negedge clk);
    man_hold = 1'b1;
    @(negedge clk);
    chk("R6 manual turns on", int'(gate_n), 0);
    repeat (29) @(negedge clk);
    man_hold = 1'b0; trel = cyc;
    wait_level(1'b1);
    chk("R6 window after release", cyc - trel, 51);
    wait_level(1'b0);
    chk("R6 interval restarts at release", cyc - trel, 101);

    // R5 one-shot, R6 long hold, R8 DONE during hold
    start(70, 1'b0, 1);
    tf = cyc;
    wait_level(1'b1);
    chk("R5 single window length", cyc - tf, 20);
    lows = 0;
    repeat (300) begin
      @(negedge clk);
      if (!gate_n) lows++;
    end
    chk("R5 no second window", lows, 0);
    man_hold = 1'b1;
    @(negedge clk);
    chk("R6 manual turns on in one-shot", int'(gate_n), 0);
    highs = 0;
    for (int i = 0; i < 99; i++) begin
      done_in = (i >= 40 && i < 45);
      @(negedge clk);
      if (gate_n) highs++;
    end
    done_in = 1'b0;
    chk("R8 DONE during hold ignored / R6 held beyond interval", highs, 0);
    man_hold = 1'b0; trel = cyc;
    wait_level(1'b1);
    chk("R6 one-shot window after release", cyc - trel, 21);
    lows = 0;
    repeat (300) begin
      @(negedge clk);
      if (!gate_n) lows++;
    end
    chk("R5 idle after manual window", lows, 0);

    // R9: strap changes after startup are ignored
    start(60, 1'b1, 1);
    periodic_strap = 1'b0;
    wait_level(1'b1);
    wait_level(1'b0); tf = cyc;
    wait_level(1'b1);
    wait_level(1'b0);
    chk("R9 still periodic", cyc - tf, 60);
    tf = cyc;
    wait_level(1'b1);
    wait_level(1'b0);
    chk("R9 still periodic again", cyc - tf, 60);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=0 (run did not complete)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end
endmodule